// File: doc/BRIEF.md
# Configurable Lookup-Table Carry Chain

This block is a row of N identical logic cells that form a dedicated carry path, of the kind placed next to the general logic of a programmable fabric. Each cell takes two operand bits and one auxiliary bit. It drives a carry into its upper neighbour and produces one result bit. Every output is a purely combinational function of the operand inputs and of the stored configuration.

Inside each cell, two 2-input tables on the operand bits give two candidate carries. One candidate applies when the cell's third input is 0 and the other when it is 1. The third input selects between them. Per cell, that third input is either the carry from the cell below or the auxiliary bit. So a carry can be injected part-way along the row, or a cell can act as a free 3-input function.

The pair of candidates puts the cell into one of four carry modes: kill, generate, pass-through, or inverted pass-through. The inverted mode makes XOR-style chains, such as parity, run along the dedicated path as well as additions and comparisons. A third table on the operand bits and the third input gives the result bit. The configuration of every cell is captured from a flat vector on a clock edge while a load strobe is high.

Top module: `lcc_chain`

## Requirements
- R1: Each cell i reports a 2-bit mode on `mode_o[2i+1:2i]`. Bit 2i+1 is the zero-carry candidate, read from the cell's table A, and bit 2i is the one-carry candidate, read from table B. Both tables are indexed by {x,y}, so table bit 2·x+y is selected.
- R2: In kill mode (code 00) the cell's carry out is 0. In generate mode (code 11) it is 1, whatever the third input.
- R3: In pass-through mode (code 01) the cell's carry out equals its third input. An all-pass-through row therefore carries the carry in to the top end unchanged.
- R4: In inverted pass-through mode (code 10) the cell's carry out is the complement of its third input. This mode is never suppressed.
- R5: When the cell's select bit is 1, its third input is its auxiliary bit `z_i[i]`. Otherwise the third input is the carry out of cell i-1, or `carry_in` for cell 0.
- R6: The result bit `result_o[i]` is bit {t,x,y} (that is, 4·t+2·x+y) of the cell's 8-bit result table, where t is the third input.
- R7: Cell i's 17 configuration bits sit at `cfg_data_i[17i+16:17i]`. Bits [3:0] are table A, bits [7:4] are table B, bits [15:8] are the result table and bit 16 is the select bit.
- R8: The configuration is captured on a rising clock edge while `cfg_load_i` is high. While it is low, changes on `cfg_data_i` have no effect on any output.
- R9: A synchronous reset clears every configuration bit. Every cell is then in kill mode with result 0, for any operand.
- R10: `carry_out` equals the carry out of the last cell. `carries_o[i]` is the carry out of cell i.
- R11: With table A = x XOR y, table B = XNOR and the result table set to the 3-input XOR, the row computes running parity. A cell with x=1, y=0 is in inverted pass-through mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset of the configuration |
| cfg_load_i | input | 1 | Capture strobe for the configuration |
| cfg_data_i | input | 17·N | Flat per-cell configuration vector |
| x_i | input | N | First operand, one bit per cell |
| y_i | input | N | Second operand, one bit per cell |
| z_i | input | N | Auxiliary bit per cell |
| carry_in | input | 1 | Carry into cell 0 |
| carry_out | output | 1 | Carry out of cell N-1 |
| carries_o | output | N | Carry out of every cell |
| result_o | output | N | Result bit of every cell |
| mode_o | output | 2·N | Mode code of every cell |

## Verification
The row is configured in turn as an adder, as a parity chain, as an unsigned greater-than comparator and as an all-generate row, and each setting is compared with bitwise reference models. The chief corner case is the inverted mode: with alternating operand bits in parity mode, a design that folded code 10 into kill or pass-through would give the wrong parity on every other cell. A full-length pass-through with carry in set catches a chain that breaks or re-times the ripple. An injected auxiliary carry half-way up the row catches a wrong select polarity, which would let the lower half's carry leak into the upper sum. Changing the configuration data with the strobe low, and resetting after a load, catch registers that capture without the strobe or survive reset.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
    localparam int CFG_W = 17;

    typedef struct packed {
        logic       use_z;
        logic [7:0] res_tbl;
        logic [3:0] c1_tbl;
        logic [3:0] c0_tbl;
    } cell_cfg_t;

    typedef enum logic [1:0] {
        MODE_KILL = 2'b00,
        MODE_PASS = 2'b01,
        MODE_INV  = 2'b10,
        MODE_GEN  = 2'b11
    } carry_mode_e;
endpackage

// File: rtl/lcc_lut.sv
module lcc_lut #(
    parameter int K = 2,
    localparam int ENTRIES = 1 << K
) (
    input  logic [ENTRIES-1:0] tbl_i,
    input  logic [K-1:0]       idx_i,
    output logic               out_o
);
    assign out_o = tbl_i[idx_i];
endmodule

// File: rtl/lcc_cfg_reg.sv
module lcc_cfg_reg #(
    parameter int N = 8,
    localparam int W = N * lcc_pkg::CFG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load_i) begin
            cfg_q <= data_i;
        end
    end
endmodule

// File: rtl/lcc_cell.sv
module lcc_cell
    import lcc_pkg::*;
(
    input  cell_cfg_t   cfg_i,
    input  logic        x_i,
    input  logic        y_i,
    input  logic        z_i,
    input  logic        prev_c_i,
    output logic        cout_o,
    output logic        res_o,
    output carry_mode_e mode_o
);
    logic third;
    logic cand0;
    logic cand1;

    assign third = cfg_i.use_z ? z_i : prev_c_i;

    lcc_lut #(.K(2)) u_tbl_a (
        .tbl_i (cfg_i.c0_tbl),
        .idx_i ({x_i, y_i}),
        .out_o (cand0)
    );

    lcc_lut #(.K(2)) u_tbl_b (
        .tbl_i (cfg_i.c1_tbl),
        .idx_i ({x_i, y_i}),
        .out_o (cand1)
    );

    lcc_lut #(.K(3)) u_tbl_res (
        .tbl_i (cfg_i.res_tbl),
        .idx_i ({third, x_i, y_i}),
        .out_o (res_o)
    );

    assign mode_o = carry_mode_e'({cand0, cand1});

    always_comb begin
        unique case (mode_o)
            MODE_KILL: cout_o = 1'b0;
            MODE_GEN:  cout_o = 1'b1;
            MODE_PASS: cout_o = third;
            MODE_INV:  cout_o = ~third;
            default:   cout_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/lcc_chain.sv
module lcc_chain
    import lcc_pkg::*;
#(
    parameter int N = 8,
    localparam int CW = N * CFG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_load_i,
    input  logic [CW-1:0]   cfg_data_i,
    input  logic [N-1:0]    x_i,
    input  logic [N-1:0]    y_i,
    input  logic [N-1:0]    z_i,
    input  logic            carry_in,
    output logic            carry_out,
    output logic [N-1:0]    carries_o,
    output logic [N-1:0]    result_o,
    output logic [2*N-1:0]  mode_o
);
    logic [CW-1:0] cfg_q;
    logic [N:0]    link;

    lcc_cfg_reg #(.N(N)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load_i (cfg_load_i),
        .data_i (cfg_data_i),
        .cfg_q  (cfg_q)
    );

    assign link[0] = carry_in;

    for (genvar i = 0; i < N; i++) begin : g_cell
        carry_mode_e cell_mode;

        lcc_cell u_cell (
            .cfg_i    (cell_cfg_t'(cfg_q[i*CFG_W +: CFG_W])),
            .x_i      (x_i[i]),
            .y_i      (y_i[i]),
            .z_i      (z_i[i]),
            .prev_c_i (link[i]),
            .cout_o   (link[i+1]),
            .res_o    (result_o[i]),
            .mode_o   (cell_mode)
        );

        assign mode_o[2*i +: 2] = cell_mode;
        assign carries_o[i]     = link[i+1];
    end

    assign carry_out = link[N];
endmodule

// File: rtl/lcc_chain_chk.sv
module lcc_chain_chk #(
    parameter int N = 8,
    localparam int CFG_W = 17,
    localparam int CW = N * CFG_W
) (
    input logic           clk,
    input logic           rst,
    input logic           cfg_load_i,
    input logic [CW-1:0]  cfg_data_i,
    input logic [N-1:0]   z_i,
    input logic           carry_in,
    input logic           carry_out,
    input logic [N-1:0]   carries_o,
    input logic [N-1:0]   result_o,
    input logic [2*N-1:0] mode_o,
    input logic [CW-1:0]  cfg_q
);
    for (genvar i = 0; i < N; i++) begin : g_chk
        logic prev_c;
        logic tin;
        if (i == 0) begin : g_first
            assign prev_c = carry_in;
        end else begin : g_rest
            assign prev_c = carries_o[i-1];
        end
        assign tin = cfg_q[i*CFG_W + 16] ? z_i[i] : prev_c;

        // R2
        p_kill_r2: assert property (@(posedge clk) disable iff (rst)
            (mode_o[2*i +: 2] == 2'b00) |-> (carries_o[i] == 1'b0));
        p_gen_r2: assert property (@(posedge clk) disable iff (rst)
            (mode_o[2*i +: 2] == 2'b11) |-> (carries_o[i] == 1'b1));
        // R3
        p_pass_r3: assert property (@(posedge clk) disable iff (rst)
            (mode_o[2*i +: 2] == 2'b01) |-> (carries_o[i] == tin));
        // R4
        p_inv_r4: assert property (@(posedge clk) disable iff (rst)
            (mode_o[2*i +: 2] == 2'b10) |-> (carries_o[i] == !tin));
    end

    // R8
    p_load_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_load_i |=> (cfg_q == $past(cfg_data_i)));
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !cfg_load_i |=> $stable(cfg_q));
    // R9
    p_clear_r9: assert property (@(posedge clk)
        rst |=> (cfg_q == '0));
    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_q == '0) |-> (result_o == '0 && mode_o == '0 && carry_out == 1'b0));
endmodule

bind lcc_chain lcc_chain_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_load_i (cfg_load_i),
    .cfg_data_i (cfg_data_i),
    .z_i        (z_i),
    .carry_in   (carry_in),
    .carry_out  (carry_out),
    .carries_o  (carries_o),
    .result_o   (result_o),
    .mode_o     (mode_o),
    .cfg_q      (cfg_q)
);

// File: tb/sim_lcc_chain.sv
`timescale 1ns/1ps
module sim_lcc_chain;
    localparam int N  = 8;
    localparam int CW = N * 17;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_load_i = 1'b0;
    logic [CW-1:0]  cfg_data_i = '0;
    logic [N-1:0]   x_i = '0, y_i = '0, z_i = '0;
    logic           carry_in = 1'b0;
    logic           carry_out;
    logic [N-1:0]   carries_o, result_o;
    logic [2*N-1:0] mode_o;

    always #2.5 clk = ~clk;

    lcc_chain #(.N(N)) u0 (
        .clk(clk), .rst(rst), .cfg_load_i(cfg_load_i), .cfg_data_i(cfg_data_i),
        .x_i(x_i), .y_i(y_i), .z_i(z_i), .carry_in(carry_in),
        .carry_out(carry_out), .carries_o(carries_o), .result_o(result_o),
        .mode_o(mode_o)
    );

    typedef struct {
        logic [N-1:0]   res;
        logic [N-1:0]   carr;
        logic [2*N-1:0] md;
        logic           co;
        bit             chk_res;
        bit             chk_carr;
        string          tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    localparam logic [7:0] XOR3 = 8'b1001_0110;

    function automatic logic [CW-1:0] make_cfg(logic [3:0] ta, logic [3:0] tb,
                                               logic [7:0] tr, logic [N-1:0] zm);
        logic [CW-1:0] v;
        for (int i = 0; i < N; i++) v[i*17 +: 17] = {zm[i], tr, tb, ta};
        return v;
    endfunction

    task automatic load_cfg(logic [CW-1:0] v);
        @(posedge clk); #1;
        cfg_load_i = 1'b1;
        cfg_data_i = v;
        @(posedge clk); #1;
        cfg_load_i = 1'b0;
    endtask

    task automatic drive(logic [N-1:0] x, logic [N-1:0] y, logic [N-1:0] z,
                         logic c, exp_t e);
        @(posedge clk); #1;
        x_i = x; y_i = y; z_i = z; carry_in = c;
        q.push_back(e);
    endtask

    // adder: table A = x&y (4'b1000), table B = x|y (4'b1110), result = XOR3
    task automatic run_add(logic [N-1:0] x, logic [N-1:0] y, logic [N-1:0] z,
                           logic c, logic [N-1:0] zm, string tag);
        exp_t e;
        logic cc = c;
        for (int i = 0; i < N; i++) begin
            if (zm[i]) cc = z[i];
            e.res[i] = x[i] ^ y[i] ^ cc;
            cc = (x[i] & y[i]) | (cc & (x[i] | y[i]));
            e.carr[i] = cc;
            e.md[2*i+1] = x[i] & y[i];
            e.md[2*i]   = x[i] | y[i];
        end
        e.co = cc; e.chk_res = 1; e.chk_carr = 1; e.tag = tag;
        drive(x, y, z, c, e);
    endtask

    // parity: table A = x^y (4'b0110), table B = xnor (4'b1001), result = XOR3
    task automatic run_par(logic [N-1:0] x, logic [N-1:0] y, logic c, string tag);
        exp_t e;
        logic p = c;
        for (int i = 0; i < N; i++) begin
            p = p ^ x[i] ^ y[i];
            e.res[i] = p;
            e.carr[i] = p;
            e.md[2*i+1] = x[i] ^ y[i];
            e.md[2*i]   = ~(x[i] ^ y[i]);
        end
        e.co = p; e.chk_res = 1; e.chk_carr = 1; e.tag = tag;
        drive(x, y, '0, c, e);
    endtask

    // comparator: table A = x&~y (4'b0100), table B = x|~y (4'b1101), result table 0
    task automatic run_cmp(logic [N-1:0] x, logic [N-1:0] y, logic c, string tag);
        exp_t e;
        for (int i = 0; i < N; i++) begin
            e.md[2*i+1] = x[i] & ~y[i];
            e.md[2*i]   = x[i] | ~y[i];
        end
        e.co = c ? (x >= y) : (x > y);
        e.res = '0; e.carr = '0; e.chk_res = 1; e.chk_carr = 0; e.tag = tag;
        drive(x, y, '0, c, e);
    endtask

    task automatic run_fixed(logic [N-1:0] x, logic [N-1:0] y, logic c,
                             logic [N-1:0] carr, logic [N-1:0] res,
                             logic [2*N-1:0] md, string tag);
        exp_t e;
        e.res = res; e.carr = carr; e.md = md; e.co = carr[N-1];
        e.chk_res = 1; e.chk_carr = 1; e.tag = tag;
        drive(x, y, x ^ y, c, e);
    endtask

    // monitor: compares away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            bit bad = 0;
            e = q.pop_front();
            n_cmp++;
            if (carry_out !== e.co) begin
                bad = 1;
                $display("FAIL %s carry_out act=%b exp=%b", e.tag, carry_out, e.co);
            end
            if (mode_o !== e.md) begin
                bad = 1;
                $display("FAIL %s mode act=%h exp=%h", e.tag, mode_o, e.md);
            end
            if (e.chk_carr && carries_o !== e.carr) begin
                bad = 1;
                $display("FAIL %s carries act=%h exp=%h", e.tag, carries_o, e.carr);
            end
            if (e.chk_res && result_o !== e.res) begin
                bad = 1;
                $display("FAIL %s result act=%h exp=%h", e.tag, result_o, e.res);
            end
            if (bad) n_bad++;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] add_cfg, par_cfg, cmp_cfg, gen_cfg;
        add_cfg = make_cfg(4'b1000, 4'b1110, XOR3, '0);
        par_cfg = make_cfg(4'b0110, 4'b1001, XOR3, '0);
        cmp_cfg = make_cfg(4'b0100, 4'b1101, 8'h00, '0);
        gen_cfg = make_cfg(4'b1111, 4'b1111, 8'h00, '0);

        repeat (3) @(posedge clk);
        // R9: held in reset, every cell kills, result 0
        run_fixed('1, '1, 1'b1, '0, '0, '0, "R9 reset");
        @(posedge clk); #1; rst = 1'b0;

        // R1 R2 R3 R6 R7 R10: adder
        load_cfg(add_cfg);
        run_add(8'd0, 8'd0, '0, 1'b0, '0, "R6 add zero");
        run_add(8'hFF, 8'h00, '0, 1'b1, '0, "R3 all pass-through");
        run_add(8'hFF, 8'hFF, '0, 1'b0, '0, "R2 generate");
        run_add(8'h5A, 8'h3C, '0, 1'b0, '0, "R7 R1 add");
        for (int k = 0; k < 20; k++)
            run_add(N'($urandom), N'($urandom), '0, 1'($urandom), '0, "R10 add rand");

        // R8: data change without strobe is ignored
        @(posedge clk); #1; cfg_data_i = gen_cfg;
        @(posedge clk); #1;
        run_add(8'h81, 8'h7F, '0, 1'b0, '0, "R8 hold");

        // R5: auxiliary carry injected at cell 4
        load_cfg(make_cfg(4'b1000, 4'b1110, XOR3, 8'h10));
        run_add(8'h0F, 8'h01, 8'h10, 1'b0, 8'h10, "R5 inject one");
        run_add(8'h0F, 8'h01, 8'h00, 1'b1, 8'h10, "R5 inject zero");
        for (int k = 0; k < 10; k++)
            run_add(N'($urandom), N'($urandom), N'($urandom), 1'($urandom), 8'h10, "R5 rand");

        // R11 R4: parity chain, alternating inverted pass-through
        load_cfg(par_cfg);
        run_par(8'h55, 8'h00, 1'b0, "R11 R4 alternating");
        run_par(8'hAA, 8'h00, 1'b1, "R4 alternating cin");
        run_par(8'hFF, 8'h00, 1'b0, "R4 all inverted");
        run_par(8'h00, 8'h00, 1'b1, "R3 parity pass");
        for (int k = 0; k < 20; k++)
            run_par(N'($urandom), N'($urandom), 1'($urandom), "R11 rand");

        // R10: unsigned comparator on carry_out
        load_cfg(cmp_cfg);
        run_cmp(8'h80, 8'h7F, 1'b0, "R10 cmp gt");
        run_cmp(8'h42, 8'h42, 1'b0, "R10 cmp eq");
        run_cmp(8'h42, 8'h42, 1'b1, "R10 cmp eq cin");
        run_cmp(8'h10, 8'h11, 1'b1, "R10 cmp lt");
        for (int k = 0; k < 20; k++)
            run_cmp(N'($urandom), N'($urandom), 1'($urandom), "R10 cmp rand");

        // R2: generate everywhere
        load_cfg(gen_cfg);
        run_fixed(8'h3C, 8'hC3, 1'b0, '1, '0, '1, "R2 all generate");

        // R9: reset after load clears configuration
        @(posedge clk); #1; rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        run_fixed(8'hA5, 8'h5A, 1'b1, '0, '0, '0, "R9 reset after load");

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule